// File: doc/BRIEF.md
# Triggered Reload Down-Counter Timer

This block is a down-counting timer with a separate reload value. A four-state controller decides when it counts. After reset the controller is stopped. Once enabled, it either waits for a start trigger or loads at once. A load copies the reload value into the counter, and counting then begins. A start trigger comes from a one-cycle software strobe or from a rising edge on an asynchronous external pin. The counter steps down once for each count-enable tick.

When the counter steps below zero, the block sets a sticky underflow flag. In reload mode it then reloads and keeps running. In one-shot mode it drops back to wait for a new trigger.

A toggle output gives a waveform:
- In reload mode it inverts on every underflow, so it makes a square wave.
- In one-shot mode it is high for exactly the span of a run.

The flag raises an interrupt request when the interrupt enable is set. Every pin is a plain control or status signal, so there is no stream handshake and no back-pressure.

Top module: `rld_timer`

## Requirements
- R1: After reset, state_o is 0 (stopped), count_o is 0, and uf_flag_o, irq_o and tog_o are 0. The state encoding is 0 stopped, 1 waiting, 2 loading, 3 running.
- R2: While enable_i is low, the next state is 0 from any state. In state 0 the count holds its value and ext_trig_i has no effect.
- R3: From state 0, raising enable_i with sw_trig_i low enters state 1. Raising it with sw_trig_i high enters state 2.
- R4: In state 1, a sw_trig_i strobe moves to state 2. A rising edge on ext_trig_i does the same, and it reaches state 2 on the third clock edge after the pin rises (two synchronizer stages plus the edge detector).
- R5: State 2 lasts one cycle. It writes reload_val_i into the count and then enters state 3.
- R6: In state 3 the count decrements once per cycle with tick_i high and holds when tick_i is low. An underflow is a tick at count 0, and the count then becomes all ones.
- R7: With reload_mode_i high, an underflow returns to state 2. With tick_i held high, successive underflows are therefore reload+2 cycles apart, and tog_o inverts on each one.
- R8: With reload_mode_i low, an underflow enters state 1 with the count at all ones. tog_o is high exactly while in state 3, for reload+1 cycles when tick_i is held high.
- R9: A sw_trig_i strobe in state 3 goes to state 2 and restarts the count from reload_val_i.
- R10: An underflow sets uf_flag_o, which stays set until a flag_clr_i pulse. irq_o is uf_flag_o gated by irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Timer enable |
| reload_mode_i | input | 1 | 1 = reload on underflow, 0 = one-shot |
| sw_trig_i | input | 1 | One-cycle software start strobe |
| ext_trig_i | input | 1 | Asynchronous external trigger, rising edge active |
| tick_i | input | 1 | Count-enable tick |
| reload_val_i | input | WIDTH | Reload value |
| flag_clr_i | input | 1 | Clears the underflow flag |
| irq_en_i | input | 1 | Interrupt enable |
| count_o | output | WIDTH | Current count |
| state_o | output | 2 | Controller state |
| uf_flag_o | output | 1 | Sticky underflow flag |
| irq_o | output | 1 | Interrupt request |
| tog_o | output | 1 | Toggle / pulse output |

## Verification
The embedded assertions check rules that apply on every cycle:
- the count holds while stopped;
- the load cycle is always followed by a run with the count equal to the reload value;
- a disable always forces the stop state;
- the flag is set after each underflow;
- one-shot underflows fall back to waiting.

Some behaviour is only visible over whole scenarios, so the bench covers it:
- the synchronizer latency of the external trigger;
- that the trigger is ignored while stopped;
- the exact reload+2 period over every reload value of a 4-bit build;
- the one-shot pulse width over the same sweep;
- restart by a software strobe.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;
  typedef enum logic [1:0] {
    ST_STOP = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOAD = 2'd2,
    ST_RUN  = 2'd3
  } tmr_state_e;
endpackage

// File: rtl/rld_trig_sync.sv
module rld_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/rld_fsm.sv
module rld_fsm
  import rld_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       reload_mode_i,
  input  logic       sw_trig_i,
  input  logic       ext_rise_i,
  input  logic       underflow_i,
  output tmr_state_e state_o
);
  tmr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!enable_i) st_d = ST_STOP;
    else begin
      unique case (st_q)
        ST_STOP: st_d = sw_trig_i ? ST_LOAD : ST_WAIT;
        ST_WAIT: if (sw_trig_i || ext_rise_i) st_d = ST_LOAD;
        ST_LOAD: st_d = ST_RUN;
        ST_RUN: begin
          if (sw_trig_i)        st_d = ST_LOAD;
          else if (underflow_i) st_d = reload_mode_i ? ST_LOAD : ST_WAIT;
        end
        default: st_d = ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_STOP;
    else        st_q <= st_d;

  assign state_o = st_q;

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> st_q == ST_STOP); // R2
  AST_LOAD_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD && enable_i) |=> st_q == ST_RUN); // R5
  AST_ONESHOT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow_i && !reload_mode_i && enable_i && !sw_trig_i) |=> st_q == ST_WAIT); // R8
endmodule

// File: rtl/rld_counter.sv
module rld_counter
  import rld_timer_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_state_e       state_i,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] reload_val_i,
  output logic [WIDTH-1:0] count_o,
  output logic             underflow_o
);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  logic [WIDTH-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                              cnt_q <= ZERO;
    else if (state_i == ST_LOAD)             cnt_q <= reload_val_i;
    else if (state_i == ST_RUN && tick_i)    cnt_q <= cnt_q - ONE;

  assign underflow_o = (state_i == ST_RUN) && tick_i && (cnt_q == ZERO);
  assign count_o     = cnt_q;

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_STOP) |=> $stable(cnt_q)); // R2
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i == ST_LOAD) |=> cnt_q == $past(reload_val_i)); // R5
  AST_WRAP_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> &cnt_q); // R6
endmodule

// File: rtl/rld_outputs.sv
module rld_outputs
  import rld_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tmr_state_e state_i,
  input  logic       reload_mode_i,
  input  logic       underflow_i,
  input  logic       flag_clr_i,
  input  logic       irq_en_i,
  output logic       uf_flag_o,
  output logic       irq_o,
  output logic       tog_o
);
  logic flag_q, tog_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           flag_q <= 1'b0;
    else if (underflow_i) flag_q <= 1'b1;
    else if (flag_clr_i)  flag_q <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           tog_q <= 1'b0;
    else if (underflow_i) tog_q <= ~tog_q;

  assign uf_flag_o = flag_q;
  assign irq_o     = flag_q & irq_en_i;
  assign tog_o     = reload_mode_i ? tog_q : (state_i == ST_RUN);

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_i |=> flag_q); // R10
  AST_TOG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_i |=> tog_q != $past(tog_q)); // R7
endmodule

// File: rtl/rld_timer.sv
module rld_timer
  import rld_timer_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             reload_mode_i,
  input  logic             sw_trig_i,
  input  logic             ext_trig_i,
  input  logic             tick_i,
  input  logic [WIDTH-1:0] reload_val_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic [WIDTH-1:0] count_o,
  output logic [1:0]       state_o,
  output logic             uf_flag_o,
  output logic             irq_o,
  output logic             tog_o
);
  logic       ext_rise, underflow;
  tmr_state_e st;

  rld_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_trig_i), .rise_o(ext_rise));

  rld_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
    .reload_mode_i(reload_mode_i), .sw_trig_i(sw_trig_i),
    .ext_rise_i(ext_rise), .underflow_i(underflow), .state_o(st));

  rld_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .state_i(st), .tick_i(tick_i),
    .reload_val_i(reload_val_i), .count_o(count_o), .underflow_o(underflow));

  rld_outputs u_out (
    .clk(clk), .rst_n(rst_n), .state_i(st), .reload_mode_i(reload_mode_i),
    .underflow_i(underflow), .flag_clr_i(flag_clr_i), .irq_en_i(irq_en_i),
    .uf_flag_o(uf_flag_o), .irq_o(irq_o), .tog_o(tog_o));

  assign state_o = st;
endmodule

// File: tb/tb_rld_timer.sv
module tb_rld_timer;
  localparam int W = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, rmode = 0, sw = 0, ext = 0, tick = 0, fclr = 0, irqen = 0;
  logic [W-1:0] rval = '0;
  logic [W-1:0] count;
  logic [1:0]   state;
  logic         flag, irq, tog;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  rld_timer #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .reload_mode_i(rmode),
    .sw_trig_i(sw), .ext_trig_i(ext), .tick_i(tick), .reload_val_i(rval),
    .flag_clr_i(fclr), .irq_en_i(irqen), .count_o(count), .state_o(state),
    .uf_flag_o(flag), .irq_o(irq), .tog_o(tog));

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    step(3);
    rst_n = 1'b1;
    step();
    chk("R1 state", state, 0); chk("R1 count", count, 0);
    chk("R1 flag", flag, 0); chk("R1 irq", irq, 0); chk("R1 tog", tog, 0);

    // R2: external edge ignored while stopped
    rval = 4'd9;
    ext = 1; step(4); ext = 0; step(2);
    chk("R2 stop ignores ext", state, 0); chk("R2 count held", count, 0);

    // R3: enable without trigger -> wait
    enable = 1; step();
    chk("R3 enter wait", state, 1); chk("R2 count held in wait", count, 0);

    // R4: external rising edge -> load on third edge
    ext = 1; step(2);
    chk("R4 not yet loading", state, 1);
    step();
    chk("R4 ext load", state, 2);
    step();
    chk("R5 run after load", state, 3); chk("R5 load value", count, 9);
    ext = 0;

    // R6: tick gating
    step(5);
    chk("R6 hold without tick", count, 9);
    tick = 1; step(3); tick = 0;
    chk("R6 decrement", count, 6);

    // R9: software restart in run
    sw = 1; step(); sw = 0;
    chk("R9 restart load", state, 2);
    step();
    chk("R9 restart value", count, 9);

    // R2 disable, R3 direct load
    enable = 0; step();
    chk("R2 disable stops", state, 0);
    step(3);
    chk("R2 stopped count held", count, 9);
    enable = 1; sw = 1; step(); sw = 0;
    chk("R3 direct load", state, 2);
    step();

    // R7: reload period sweep
    rmode = 1; tick = 1;
    for (int r = 0; r < (1 << W); r++) begin
      logic t0;
      rval = W'(r);
      sw = 1; step(); sw = 0;
      t0 = tog; n = 0;
      while (tog == t0 && n < 100) begin step(); n++; end
      t0 = tog; n = 0;
      while (tog == t0 && n < 100) begin step(); n++; end
      chk($sformatf("R7 period r=%0d", r), n, r + 2);
    end
    tick = 0; step(2);

    // R10: sticky flag and interrupt gating
    chk("R10 flag set", flag, 1); chk("R10 irq gated", irq, 0);
    irqen = 1; step();
    chk("R10 irq on", irq, 1);
    step(3);
    chk("R10 flag sticky", flag, 1);
    fclr = 1; step(); fclr = 0;
    chk("R10 flag cleared", flag, 0); chk("R10 irq off", irq, 0);

    // R8: one-shot pulse sweep
    rmode = 0; tick = 1; n = 0;
    while (state != 1 && n < 100) begin step(); n++; end
    chk("R8 reach wait", state, 1);
    for (int r = 0; r < (1 << W); r++) begin
      rval = W'(r);
      sw = 1; step(); sw = 0;
      step(); n = 0;
      while (tog && n < 100) begin step(); n++; end
      chk($sformatf("R8 pulse r=%0d", r), n, r + 1);
      chk($sformatf("R8 back to wait r=%0d", r), state, 1);
      chk($sformatf("R8 count ones r=%0d", r), count, (1 << W) - 1);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule